// File: doc/BRIEF.md
# Elapsed-Seconds Counter with Stoppable Time Base

This block keeps a free-running binary count of elapsed seconds. A one-cycle enable arriving at 32.768 kHz feeds a prescaler, and each prescaler rollover is a one-second tick that advances the count. A stop bit in a control register halts counting. When main power is lost and only backup power is present, the same bit also freezes the prescaler, so the time base is stopped as well. With main power present the prescaler always runs, and the tick stays visible even while the count is held.

The block also holds the backup-charger configuration byte and decodes it into enable, diode and resistor select lines. A 4-bit arming key gates the whole charger, so a stray write cannot switch it on. Software reaches the count bytes, the control byte and the charger byte through a plain byte-wide write strobe and a combinational read port. These are register ports with no back-pressure: every write is taken in the cycle it is presented, and read data follows the read address within the same cycle.

Top module: `sec_counter_top`

## Requirements
- R1: While the stop bit is clear, each one-second tick adds exactly one to the 32-bit count. The count wraps from FFFFFFFFh to 0, and a carry ripples across byte boundaries.
- R2: The prescaler counts only cycles in which `tick_en` is high. `sec_tick` pulses for one cycle after every DIV such cycles (32768 by default), and the count is updated at that same clock edge.
- R3: With the stop bit (control byte bit 7) set and `main_pwr_ok` high, the prescaler keeps running and `sec_tick` keeps pulsing, but the count holds its value.
- R4: With the stop bit set and `main_pwr_ok` low, `osc_run` is low, the prescaler phase is frozen and no tick occurs. When either condition clears, the prescaler resumes from the phase it held. With the stop bit clear, counting continues even without main power.
- R5: Address map. Addresses 0 to 3 hold the count bytes, least significant first. Address 4 is the control byte: only bit 7 is stored and the other bits read 0. Address 5 is the 8-bit charger byte. Addresses 6 and 7 read 0, and writes to them change nothing.
- R6: `chg_en` is high only when charger bits 7:4 equal 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00.
- R7: When `chg_en` is high, `chg_diode` is high for diode code 10 and low for 01. Resistor code 01, 10 and 11 raise `chg_r250`, `chg_r2k` and `chg_r4k` respectively. All select lines are low when `chg_en` is low.
- R8: A write to a count byte in the same cycle as a tick wins. The written byte takes the written value, the other bytes keep their value, no increment happens, no `sec_tick` pulse is produced, and the prescaler restarts from phase 0.
- R9: After reset the count, the control byte and the charger byte are all 0, so the charger is disabled and `sec_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| main_pwr_ok | input | 1 | High while main power is valid |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write byte data |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read byte data (combinational) |
| count | output | 32 | Elapsed-seconds count |
| sec_tick | output | 1 | One-cycle pulse at each prescaler rollover |
| osc_run | output | 1 | Time base running |
| chg_en | output | 1 | Charger armed and configured validly |
| chg_diode | output | 1 | Series diode selected |
| chg_r250 | output | 1 | 250 ohm resistor selected |
| chg_r2k | output | 1 | 2 kohm resistor selected |
| chg_r4k | output | 1 | 4 kohm resistor selected |

## Verification
The properties assume that `wr_addr` and `wr_data` are stable and known whenever `wr_en` is high. They also assume that `tick_en` and `main_pwr_ok` change only between clock edges. The bench drives every input on the falling edge and holds it for a full cycle, so both assumptions hold. The bench builds the block with a divide-by-8 prescaler so that whole second periods, frozen phases and a tick colliding with a write can be reached in a few cycles. It also sweeps all 256 charger byte values.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] CHG_KEY = 4'b1010;

  typedef struct packed {
    logic en;
    logic diode;
    logic r250;
    logic r2k;
    logic r4k;
  } chg_sel_t;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;
  logic          at_last;

  assign at_last = (phase == LAST);
  assign tick    = tick_en & run & at_last & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (restart)        phase <= '0;
    else if (tick_en && run) phase <= at_last ? '0 : phase + 1'b1;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST) else $error("phase out of range"); // R2
  AST_FROZEN_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase)) else $error("phase moved while halted"); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0)) else $error("restart did not clear phase"); // R8
endmodule

// File: rtl/sc_count_regs.sv
module sc_count_regs #(
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       count_en,
  input  logic                       wr_en,
  input  logic [$clog2(CNT_W/8)-1:0] wr_idx,
  input  logic [7:0]                 wr_data,
  output logic [CNT_W-1:0]           count
);
  localparam int NB = CNT_W / 8;

  logic [NB-1:0]    byte_wr;
  logic [CNT_W-1:0] nxt;

  for (genvar b = 0; b < NB; b++) begin : g_bsel
    assign byte_wr[b] = wr_en && (wr_idx == b);
  end

  always_comb begin
    nxt = count;
    if (wr_en) begin
      for (int b = 0; b < NB; b++)
        if (byte_wr[b]) nxt[b*8 +: 8] = wr_data;
    end else if (tick && count_en) begin
      nxt = count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_en && !wr_en) |=> (count == $past(count) + 1'b1))
    else $error("count did not advance by one"); // R1
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr_en) |=> $stable(count)) else $error("count moved while stopped"); // R3
  AST_WRITE_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> (count[7:0] == $past(count[7:0])))
    else $error("write let count advance"); // R8
endmodule

// File: rtl/sc_trickle_dec.sv
module sc_trickle_dec
  import sc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [7:0] cfg,
  output chg_sel_t sel
);
  logic key_ok, diode_ok, res_ok, armed;

  assign key_ok   = (cfg[7:4] == CHG_KEY);
  assign diode_ok = (cfg[3:2] == 2'b01) || (cfg[3:2] == 2'b10);
  assign res_ok   = (cfg[1:0] != 2'b00);
  assign armed    = key_ok & diode_ok & res_ok;

  always_comb begin
    sel       = '0;
    sel.en    = armed;
    sel.diode = armed & (cfg[3:2] == 2'b10);
    sel.r250  = armed & (cfg[1:0] == 2'b01);
    sel.r2k   = armed & (cfg[1:0] == 2'b10);
    sel.r4k   = armed & (cfg[1:0] == 2'b11);
  end

  AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.r250, sel.r2k, sel.r4k})) else $error("resistor selects not one-hot"); // R7
  AST_EN_MATCHES_RES: assert property (@(posedge clk) disable iff (!rst_n)
    sel.en == (sel.r250 | sel.r2k | sel.r4k)) else $error("enable without resistor"); // R6
endmodule

// File: rtl/sec_counter_top.sv
module sec_counter_top
  import sc_pkg::*;
#(
  parameter int DIV   = 32768,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             main_pwr_ok,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] count,
  output logic             sec_tick,
  output logic             osc_run,
  output logic             chg_en,
  output logic             chg_diode,
  output logic             chg_r250,
  output logic             chg_r2k,
  output logic             chg_r4k
);
  localparam int NB = CNT_W / BYTE_W;
  localparam int BW = $clog2(NB);
  localparam logic [2:0] A_CTRL = 3'(NB);
  localparam logic [2:0] A_TRK  = 3'(NB + 1);

  logic       stop_q;
  logic [7:0] trk_q;
  logic       cnt_wr, tick_raw, tick_q;
  chg_sel_t   sel;

  assign cnt_wr  = wr_en && (wr_addr < 3'(NB));
  assign osc_run = main_pwr_ok | ~stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      trk_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) stop_q <= wr_data[7];
      if (wr_en && wr_addr == A_TRK)  trk_q  <= wr_data;
      tick_q <= tick_raw;
    end
  end

  sc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(osc_run),
    .restart(cnt_wr), .tick(tick_raw)
  );

  sc_count_regs #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_raw), .count_en(~stop_q),
    .wr_en(cnt_wr), .wr_idx(wr_addr[BW-1:0]), .wr_data(wr_data), .count(count)
  );

  sc_trickle_dec u_trk (.clk(clk), .rst_n(rst_n), .cfg(trk_q), .sel(sel));

  always_comb begin
    rd_data = '0;
    if (rd_addr < 3'(NB))     rd_data = count[rd_addr[BW-1:0]*8 +: 8];
    else if (rd_addr == A_CTRL) rd_data = {stop_q, 7'b0};
    else if (rd_addr == A_TRK)  rd_data = trk_q;
  end

  assign sec_tick  = tick_q;
  assign chg_en    = sel.en;
  assign chg_diode = sel.diode;
  assign chg_r250  = sel.r250;
  assign chg_r2k   = sel.r2k;
  assign chg_r4k   = sel.r4k;

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> ($past(main_pwr_ok) || !$past(stop_q))) else $error("tick while halted"); // R4
  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !sec_tick) else $error("tick on counter write"); // R8
endmodule

// File: tb/tb_sec_counter_top.sv
module tb_sec_counter_top;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, main_pwr_ok = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [31:0] count;
  logic sec_tick, osc_run, chg_en, chg_diode, chg_r250, chg_r2k, chg_r4k;

  int checks = 0, errors = 0;
  logic [31:0] exp_cnt;

  always #10 clk = ~clk;

  sec_counter_top #(.DIV(DIV), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .main_pwr_ok(main_pwr_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count(count), .sec_tick(sec_tick), .osc_run(osc_run),
    .chg_en(chg_en), .chg_diode(chg_diode), .chg_r250(chg_r250),
    .chg_r2k(chg_r2k), .chg_r4k(chg_r4k)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // runs n cycles; gate=1 enables tick_en only on odd cycle numbers
  task automatic run(input int n, input bit gate, output int ticks, output int first, output int off_grid);
    int en_seen = 0;
    ticks = 0; first = 0; off_grid = 0;
    for (int i = 1; i <= n; i++) begin
      tick_en = gate ? i[0] : 1'b1;
      if (tick_en) en_seen++;
      cyc();
      if (sec_tick) begin
        ticks++;
        if (first == 0) first = i;
        if (en_seen % DIV != 0) off_grid++;
      end
    end
    tick_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t, f, g;
    logic [7:0] d;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R9 reset state
    check("R9 count", count, 0);
    rd(3'd4, d); check("R9 ctrl", {24'b0, d}, 0);
    rd(3'd5, d); check("R9 trickle", {24'b0, d}, 0);
    check("R9 chg_en", {31'b0, chg_en}, 0);
    check("R9 sec_tick", {31'b0, sec_tick}, 0);

    // R2 / R1 continuous enable
    run(4 * DIV, 1'b0, t, f, g);
    check("R2 ticks", t, 4); check("R2 grid", g, 0); check("R1 count", count, 4);
    // R2 gated enable (every other cycle)
    run(4 * DIV, 1'b1, t, f, g);
    check("R2 gated ticks", t, 2); check("R2 gated grid", g, 0); check("R1 count gated", count, 6);

    // R1 wrap and carry
    for (int b = 0; b < 4; b++) wr(3'(b), 8'hFF);
    run(DIV, 1'b0, t, f, g);
    check("R1 wrap", count, 0); check("R1 wrap tick", f, DIV);
    wr(3'd0, 8'hFF);
    run(DIV, 1'b0, t, f, g);
    check("R1 carry", count, 32'h100);

    // R5 address map
    wr(3'd0, 8'h78); wr(3'd1, 8'h56); wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    check("R5 count word", count, 32'h12345678);
    for (int b = 0; b < 4; b++) begin
      rd(3'(b), d);
      check("R5 byte read", {24'b0, d}, (32'h12345678 >> (8 * b)) & 32'hFF);
    end
    wr(3'd4, 8'hFF); rd(3'd4, d); check("R5 ctrl bits", {24'b0, d}, 32'h80);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h3C); rd(3'd5, d); check("R5 trickle rw", {24'b0, d}, 32'h3C);
    wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
    rd(3'd6, d); check("R5 addr6 zero", {24'b0, d}, 0);
    rd(3'd7, d); check("R5 addr7 zero", {24'b0, d}, 0);
    check("R5 unmapped no count effect", count, 32'h12345678);
    rd(3'd4, d); check("R5 unmapped no ctrl effect", {24'b0, d}, 0);
    rd(3'd5, d); check("R5 unmapped no trickle effect", {24'b0, d}, 32'h3C);

    // R3 stop bit with main power: ticks continue, count holds
    exp_cnt = count;
    wr(3'd4, 8'h80);
    run(2 * DIV, 1'b0, t, f, g);
    check("R3 ticks continue", t, 2); check("R3 count held", count, exp_cnt);
    check("R3 osc_run", {31'b0, osc_run}, 1);

    // R4 frozen phase on backup with stop bit set
    wr(3'd4, 8'h00);
    run(3, 1'b0, t, f, g);
    check("R4 no early tick", t, 0);
    wr(3'd4, 8'h80);
    main_pwr_ok = 1'b0;
    run(20, 1'b0, t, f, g);
    check("R4 no tick frozen", t, 0); check("R4 count frozen", count, exp_cnt);
    check("R4 osc_run low", {31'b0, osc_run}, 0);
    main_pwr_ok = 1'b1;
    run(DIV - 3, 1'b0, t, f, g);
    check("R4 resume phase", f, DIV - 3); check("R4 held count", count, exp_cnt);
    wr(3'd4, 8'h00);
    main_pwr_ok = 1'b0;
    run(DIV, 1'b0, t, f, g);
    check("R4 backup counting", count, exp_cnt + 1);
    main_pwr_ok = 1'b1;

    // R8 write colliding with tick
    wr(3'd0, 8'h10);
    exp_cnt = count;
    run(DIV - 1, 1'b0, t, f, g);
    check("R8 pre no tick", t, 0);
    tick_en = 1'b1; wr(3'd0, 8'h55); tick_en = 1'b0;
    check("R8 write wins", count, {exp_cnt[31:8], 8'h55});
    check("R8 no tick pulse", {31'b0, sec_tick}, 0);
    exp_cnt = count;
    run(DIV, 1'b0, t, f, g);
    check("R8 restart phase", f, DIV); check("R8 after restart", count, exp_cnt + 1);

    // R6 / R7 exhaustive charger byte sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      logic en;
      logic [4:0] e;
      c = 8'(v);
      en = (c[7:4] == 4'b1010) && (c[3:2] == 2'b01 || c[3:2] == 2'b10) && (c[1:0] != 2'b00);
      e = {en, en && c[3:2] == 2'b10, en && c[1:0] == 2'b01, en && c[1:0] == 2'b10, en && c[1:0] == 2'b11};
      wr(3'd5, c);
      check("R6 R7 charger decode", {27'b0, chg_en, chg_diode, chg_r250, chg_r2k, chg_r4k}, {27'b0, e});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule